// File: doc/BRIEF.md
# Uninitialized Pointer and Illegal Opcode Trap Monitor

This block watches a working register file of sixteen entries and the instruction fetch path of a small processor core. It keeps one "has been written" bit per register. A register that was never written since the last reset and is then used as an address pointer counts as a fault. The monitor also looks at the upper byte of each fetched instruction and flags the one reserved value that no valid instruction uses. Either fault makes the block raise a reset request to the system reset controller.

The register file itself and the instruction decoder live outside this block. The monitor sees only their strobes: write enables with an index, pointer-use enables with an index, and the fetched upper byte with a valid qualifier. After a request has been raised, the block stays quiet until the system reset arrives. The reset then clears all the tracking again.

Top module: `uwtrap_monitor`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it is released, `trap_req_o`, `trap_cause_o` and `fault_flag_o` are all zero, and registers 0 to 14 count as never written.
- R2: Register 15 always counts as written. Using it as a pointer never causes a trap, even before any write to it.
- R3: A write strobe (`wr_en_i` with `wr_idx_i`) marks that register as written. A later pointer use of it causes no trap.
- R4: A pointer use (`ptr_en_i` with `ptr_idx_i`) of a never-written register raises `trap_req_o` in the cycle after the clock edge that samples the use. It also sets cause bit 1 (uninitialized pointer).
- R5: A fetch with `opc_valid_i` high and `opc_hi_i` equal to 0x3F raises `trap_req_o` in the cycle after it is sampled and sets cause bit 0 (illegal opcode). Any other byte value, or 0x3F with `opc_valid_i` low, raises nothing.
- R6: `fault_flag_o` is one shared status flag. It goes high together with the first request for either cause and stays high until reset.
- R7: When a write and a pointer use hit the same register in the same cycle, the use is judged on the state before that write.
- R8: `trap_req_o` is high for exactly one cycle. After that, further faults raise no request and leave `trap_cause_o` unchanged until reset.
- R9: Every reset makes registers 0 to 14 count as never written again, however many writes came before it.
- R10: If both faults are detected in the same cycle, both cause bits are set in that one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 4 | Index of the register being written |
| ptr_en_i | input | 1 | Register used as an address pointer |
| ptr_idx_i | input | 4 | Index of the pointer register |
| opc_valid_i | input | 1 | Fetched instruction is being executed |
| opc_hi_i | input | 8 | Upper byte of the fetched instruction |
| trap_req_o | output | 1 | One-cycle reset request |
| trap_cause_o | output | 2 | Bit 0 illegal opcode, bit 1 uninitialized pointer; held until reset |
| fault_flag_o | output | 1 | Shared sticky fault flag |

## Verification
The hardest case to reach from the ports is a write and a pointer use of the same never-written register in one cycle, because a trap hides any later event. The bench creates it right after a fresh reset so that nothing earlier can mask it. It then repeats the same two strobes in consecutive cycles to show the opposite outcome. To reach the detections that must be ignored after a request, the bench first lets a request fire and then applies a second fault of the other kind.

// File: rtl/uwtrap_pkg.sv
package uwtrap_pkg;
  localparam int CAUSE_W   = 2;
  localparam int CAUSE_OPC = 0;
  localparam int CAUSE_PTR = 1;
  typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/uwtrap_init_track.sv
module uwtrap_init_track #(
  parameter int NUM_REGS   = 16,
  parameter int EXEMPT_IDX = NUM_REGS - 1,
  parameter int IDX_W      = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             ptr_en_i,
  input  logic [IDX_W-1:0] ptr_idx_i,
  output logic             uninit_hit_o
);
  logic [NUM_REGS-1:0] init_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic RST_VAL = (g == EXEMPT_IDX);
    logic wr_hit;
    assign wr_hit = wr_en_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     init_q[g] <= RST_VAL;
      else if (wr_hit) init_q[g] <= 1'b1;
    end
  end

  // judged on pre-write state
  assign uninit_hit_o = ptr_en_i && !init_q[ptr_idx_i];

  assert_exempt_safe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_en_i && ptr_idx_i == IDX_W'(EXEMPT_IDX)) |-> !uninit_hit_o);
  assert_write_marks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> init_q[$past(wr_idx_i)]);
  assert_same_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ptr_en_i && wr_idx_i == ptr_idx_i && !init_q[ptr_idx_i]) |-> uninit_hit_o);
endmodule

// File: rtl/uwtrap_opc_check.sv
module uwtrap_opc_check #(
  parameter int               OPC_W       = 8,
  parameter logic [OPC_W-1:0] ILLEGAL_OPC = 8'h3F
) (
  input  logic             opc_valid_i,
  input  logic [OPC_W-1:0] opc_hi_i,
  output logic             opc_hit_o
);
  assign opc_hit_o = opc_valid_i && (opc_hi_i == ILLEGAL_OPC);
endmodule

// File: rtl/uwtrap_latch.sv
module uwtrap_latch
  import uwtrap_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   opc_hit_i,
  input  logic   ptr_hit_i,
  output logic   trap_req_o,
  output cause_t cause_o,
  output logic   flag_o
);
  logic   locked_q, req_q;
  cause_t cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      req_q    <= 1'b0;
      cause_q  <= '0;
    end else begin
      req_q <= 1'b0;
      if (!locked_q && (opc_hit_i || ptr_hit_i)) begin
        req_q                <= 1'b1;
        locked_q             <= 1'b1;
        cause_q[CAUSE_OPC]   <= opc_hit_i;
        cause_q[CAUSE_PTR]   <= ptr_hit_i;
      end
    end
  end

  assign trap_req_o = req_q;
  assign cause_o    = cause_q;
  assign flag_o     = locked_q;

  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o |=> !trap_req_o);
  assert_locked_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |=> ($stable(cause_o) && !trap_req_o && flag_o));
  assert_req_has_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o |-> (flag_o && cause_o != '0));
endmodule

// File: rtl/uwtrap_monitor.sv
module uwtrap_monitor
  import uwtrap_pkg::*;
#(
  parameter int               NUM_REGS    = 16,
  parameter int               EXEMPT_IDX  = NUM_REGS - 1,
  parameter int               OPC_W       = 8,
  parameter logic [OPC_W-1:0] ILLEGAL_OPC = 8'h3F,
  localparam int              IDX_W       = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             ptr_en_i,
  input  logic [IDX_W-1:0] ptr_idx_i,
  input  logic             opc_valid_i,
  input  logic [OPC_W-1:0] opc_hi_i,
  output logic             trap_req_o,
  output logic [1:0]       trap_cause_o,
  output logic             fault_flag_o
);
  logic   ptr_hit, opc_hit;
  cause_t cause;

  uwtrap_init_track #(.NUM_REGS(NUM_REGS), .EXEMPT_IDX(EXEMPT_IDX), .IDX_W(IDX_W)) u_track (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .ptr_en_i, .ptr_idx_i,
    .uninit_hit_o(ptr_hit)
  );

  uwtrap_opc_check #(.OPC_W(OPC_W), .ILLEGAL_OPC(ILLEGAL_OPC)) u_opc (
    .opc_valid_i, .opc_hi_i, .opc_hit_o(opc_hit)
  );

  uwtrap_latch u_latch (
    .clk_i, .rst_ni, .opc_hit_i(opc_hit), .ptr_hit_i(ptr_hit),
    .trap_req_o, .cause_o(cause), .flag_o(fault_flag_o)
  );

  assign trap_cause_o = cause;

  assert_ptr_trap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_hit && !fault_flag_o) |=> (trap_req_o && trap_cause_o[CAUSE_PTR]));
  assert_opc_trap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opc_valid_i && opc_hi_i == ILLEGAL_OPC && !fault_flag_o) |=> (trap_req_o && trap_cause_o[CAUSE_OPC]));
  assert_no_spurious_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ptr_hit && !opc_hit) |=> !trap_req_o);
endmodule

// File: tb/sim_uwtrap_monitor.sv
module sim_uwtrap_monitor;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0, ptr_en = 1'b0, ov = 1'b0;
  logic [3:0] wr_idx = '0, ptr_idx = '0;
  logic [7:0] opc = '0;
  logic       req;
  logic [1:0] cause;
  logic       flag;

  int nvec = 0, nerr = 0;
  logic [15:0] m_init;
  logic        m_lock;
  logic [1:0]  m_cause;
  logic        m_req;

  always #10 clk = ~clk;

  uwtrap_monitor u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .ptr_en_i(ptr_en), .ptr_idx_i(ptr_idx), .opc_valid_i(ov), .opc_hi_i(opc),
    .trap_req_o(req), .trap_cause_o(cause), .fault_flag_o(flag)
  );

  task automatic chk(string tag);
    nvec++;
    if ({req, cause, flag} !== {m_req, m_cause, m_lock}) begin
      nerr++;
      $display("FAIL %s: req/cause/flag got %b/%b/%b exp %b/%b/%b",
               tag, req, cause, flag, m_req, m_cause, m_lock);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    m_init = 16'h8000; m_lock = 1'b0; m_cause = 2'b00; m_req = 1'b0;
    @(negedge clk);
    chk("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after reset");
  endtask

  // drive one cycle of stimulus at a negedge, sample at the following negedge
  task automatic step(string tag, logic we, logic [3:0] wi, logic pe, logic [3:0] pi,
                      logic v, logic [7:0] o);
    logic u, oh;
    wr_en = we; wr_idx = wi; ptr_en = pe; ptr_idx = pi; ov = v; opc = o;
    u  = pe && !m_init[pi];
    oh = v && (o == 8'h3F);
    if (!m_lock && (u || oh)) begin
      m_req = 1'b1; m_lock = 1'b1; m_cause = {u, oh};
    end else m_req = 1'b0;
    if (we) m_init[wi] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; ptr_en = 1'b0; ov = 1'b0;
    chk(tag);
    m_req = 1'b0;
  endtask

  task automatic idle(string tag);
    step(tag, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 8'h00);
  endtask

  initial begin
    #(200000 * 20);
    nerr++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    do_reset();
    // R2/R4: pointer use of every register straight after reset
    for (int i = 0; i < 16; i++) begin
      do_reset();
      step(i == 15 ? "R2 exempt ptr" : "R4 uninit ptr", 1'b0, 4'd0, 1'b1, 4'(i), 1'b0, 8'h00);
      idle("R8 pulse ends");
    end
    // R3: write then use; neighbour still uninitialized
    for (int i = 0; i < 16; i++) begin
      do_reset();
      step("R3 write", 1'b1, 4'(i), 1'b0, 4'd0, 1'b0, 8'h00);
      step("R3 use written", 1'b0, 4'd0, 1'b1, 4'(i), 1'b0, 8'h00);
      step("R4 use neighbour", 1'b0, 4'd0, 1'b1, 4'((i + 1) % 16), 1'b0, 8'h00);
    end
    // R5: full opcode byte sweep
    do_reset();
    for (int v = 0; v < 256; v++) begin
      step("R5 opcode sweep", 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 8'(v));
      if (v == 8'h3F) do_reset();
    end
    step("R5 invalid 3F", 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 8'h3F);
    // R7: same-cycle write and use
    do_reset();
    step("R7 same cycle", 1'b1, 4'd3, 1'b1, 4'd3, 1'b0, 8'h00);
    do_reset();
    step("R7 write first", 1'b1, 4'd3, 1'b0, 4'd0, 1'b0, 8'h00);
    step("R7 use next", 1'b0, 4'd0, 1'b1, 4'd3, 1'b0, 8'h00);
    // R6/R8: after a pointer trap, an opcode fault is ignored
    do_reset();
    step("R6 ptr trap", 1'b0, 4'd0, 1'b1, 4'd7, 1'b0, 8'h00);
    idle("R8 one cycle");
    step("R8 ignored opc", 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 8'h3F);
    step("R8 ignored ptr", 1'b0, 4'd0, 1'b1, 4'd2, 1'b0, 8'h00);
    idle("R6 flag sticky");
    // R6: opcode trap also sets the flag, later ptr fault ignored
    do_reset();
    step("R6 opc trap", 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 8'h3F);
    step("R8 ignored ptr2", 1'b0, 4'd0, 1'b1, 4'd0, 1'b0, 8'h00);
    // R9: reset forgets writes
    do_reset();
    for (int i = 0; i < 15; i++) step("R9 fill", 1'b1, 4'(i), 1'b0, 4'd0, 1'b0, 8'h00);
    step("R9 filled use", 1'b0, 4'd0, 1'b1, 4'd5, 1'b0, 8'h00);
    do_reset();
    step("R9 forgotten", 1'b0, 4'd0, 1'b1, 4'd5, 1'b0, 8'h00);
    // R10: both faults in one cycle
    do_reset();
    step("R10 both", 1'b0, 4'd0, 1'b1, 4'd9, 1'b1, 8'h3F);
    idle("R10 held");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule